// File: doc/BRIEF.md
# Periodic Wakeup Down-Counter

This block is a real-time-clock-domain timer. It counts down from a programmed reload value and raises a wakeup flag each time the count passes zero, then reloads on its own. The tick comes either from the RTC clock divided by 2, 4, 8 or 16, or from an external 1 Hz strobe. One strobe mode adds 65536 to every period so that long intervals fit in a 16-bit reload. When the interrupt enable is set, the flag drives a level interrupt and a one-cycle wakeup pulse toward the interrupt controller.

Configuration is guarded. A two-value key must first be written to the key register. The reload value and the clock select can only change while the timer reports that writes are allowed, which is the case once it has been disabled. Clearing the wakeup flag is not affected by the key. The register port is plain: a write strobe with an address and data, and a separate combinational read address. There is no stream interface and no back-pressure.

Register addresses: 0 key, 1 control, 2 reload, 3 status. Control fields: sel in bits [2:0], enable in bit 3, interrupt enable in bit 4. Status fields: write-allowed in bit 0, wakeup flag in bit 1.

Top module: `rtc_wkup_timer`

## Requirements
- R1: Writes to control (address 1) and reload (address 2) take effect only after 0xCA and then 0x53 are written to the key register (address 0). Any other key value, for example 0xFF or an out-of-order value, locks the block again. A locked write leaves the register readback unchanged.
- R2: Status bit 0 (write-allowed) is 1 in the cycle after enable (control bit 3) is 0, and it drops to 0 at the first tick after enable. While it is 0, reload writes and the control sel field [2:0] are dropped, but the enable and interrupt enable bits still update.
- R3: sel 000, 001, 010 and 011 tick at RTC clock / 16, / 8, / 4 and / 2. The divider is reset while disabled, so the first wake comes exactly N*(reload+1) clock edges after the edge that sets enable.
- R4: sel 10x counts 1 Hz strobe pulses, with a period of reload+1 strobes. The RTC clock alone never advances the count.
- R5: sel 11x counts strobes with a period of reload+65537.
- R6: After each wake the counter reloads and fires again every period without software action.
- R7: Writing 0 to status bit 1 clears the wakeup flag, whether the block is locked or not. Writing 1 to that bit has no effect.
- R8: irq equals the flag ANDed with interrupt enable (control bit 4). wake pulses for exactly one cycle when irq rises. There is no wake while interrupt enable is 0.
- R9: After reset, irq and wake are 0, status reads 1, control reads 0 and reload reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Active-low reset |
| sec_strobe | input | 1 | 1 Hz tick, one clk cycle wide per pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| irq | output | 1 | Level interrupt |
| wake | output | 1 | One-cycle wakeup pulse on irq rise |

## Verification
The bench goes after the exact cycle of each wake in every divider mode. A prescaler that is not cleared on disable, or an off-by-one in the reload, moves the wake by one or more edges. Broken key sequences are checked: a design that accepts 0x53 without a preceding 0xCA, or that stays unlocked after 0xFF, lets a reload write through. A design that does not gate on write-allowed changes the reload or sel while the timer runs. The 65536 extension, the flag clear while locked, and a wake with interrupt enable at 0 are also probed. Each of these shows up as a wrong readback, a missing or extra wake, or a mistimed wake.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  localparam int unsigned PRE_W = 4;        // 4-bit prescaler gives /2../16
  localparam logic [7:0]  KEY_FIRST  = 8'hCA;
  localparam logic [7:0]  KEY_SECOND = 8'h53;

  typedef enum logic [1:0] {
    REG_KEY    = 2'd0,
    REG_CTRL   = 2'd1,
    REG_RELOAD = 2'd2,
    REG_STAT   = 2'd3
  } rtcw_addr_e;

  // bit4 irq enable, bit3 enable, bits[2:0] tick select
  typedef struct packed {
    logic       ie;
    logic       en;
    logic [2:0] sel;
  } rtcw_ctrl_t;
endpackage

// File: rtl/rtcw_keylock.sv
module rtcw_keylock
  import rtcw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       unlocked
);
  typedef enum logic [1:0] {KL_LOCKED, KL_HALF, KL_OPEN} kl_state_e;
  kl_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KL_LOCKED;
    else if (key_wr) begin
      if (key_data == KEY_FIRST)                         st_q <= KL_HALF;
      else if (st_q == KL_HALF && key_data == KEY_SECOND) st_q <= KL_OPEN;
      else                                                st_q <= KL_LOCKED;
    end
  end

  assign unlocked = (st_q == KL_OPEN);

  // R1: opening only follows a second-key write
  p_open_after_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && key_data == KEY_SECOND));
endmodule

// File: rtl/rtcw_tickgen.sv
module rtcw_tickgen
  import rtcw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] sel,
  input  logic       sec_strobe,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] tap;
  logic [1:0]       idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (!en) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  // tap[g] is high once every 2^(g+1) cycles
  for (genvar g = 0; g < PRE_W; g++) begin : g_tap
    assign tap[g] = &pre_q[g:0];
  end

  assign idx  = 2'(PRE_W - 1) - sel[1:0];
  assign tick = en & (sel[2] ? sec_strobe : tap[idx]);

  // R3: the /2 mode never ticks on two consecutive cycles
  p_div2_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sel[2] && sel[1:0] == 2'b11) |=> !tick);
endmodule

// File: rtl/rtcw_downcnt.sv
module rtcw_downcnt #(
  parameter int CNT_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         tick,
  input  logic [CNT_W:0] start,
  output logic         fire
);
  logic [CNT_W:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= start;
    else if (tick) cnt_q <= (cnt_q == '0) ? start : cnt_q - 1'b1;
  end

  assign fire = tick & (cnt_q == '0);

  // R6: after a fire the count restarts from the reload value
  p_reload_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cnt_q == $past(start));
endmodule

// File: rtl/rtc_wkup_timer.sv
module rtc_wkup_timer
  import rtcw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_strobe,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq,
  output logic             wake
);
  rtcw_ctrl_t       ctrl_q, ctrl_new;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q, wr_ok_q, irq_q;
  logic             unlocked, tick, fire, load;
  logic             wr_key, wr_ctrl, wr_rel, wr_stat;
  logic [2:0]       sel_next;
  logic [CNT_W:0]   start;

  assign wr_key  = bus_wr && bus_addr == REG_KEY;
  assign wr_ctrl = bus_wr && bus_addr == REG_CTRL && unlocked;
  assign wr_rel  = bus_wr && bus_addr == REG_RELOAD && unlocked && wr_ok_q;
  assign wr_stat = bus_wr && bus_addr == REG_STAT;
  assign ctrl_new = rtcw_ctrl_t'(bus_wdata[4:0]);

  assign sel_next = (wr_ctrl && wr_ok_q) ? ctrl_new.sel : ctrl_q.sel;
  assign start    = {&sel_next[2:1], reload_q};
  assign load     = wr_ctrl && ctrl_new.en && !ctrl_q.en;

  rtcw_keylock u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(wr_key),
    .key_data(bus_wdata[7:0]), .unlocked(unlocked)
  );

  rtcw_tickgen u_tick (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .sel(ctrl_q.sel),
    .sec_strobe(sec_strobe), .tick(tick)
  );

  rtcw_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .tick(tick),
    .start(start), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '1;
      wr_ok_q  <= 1'b1;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en <= ctrl_new.en;
        ctrl_q.ie <= ctrl_new.ie;
        if (wr_ok_q) ctrl_q.sel <= ctrl_new.sel;
      end
      if (wr_rel) reload_q <= bus_wdata;
      if (!ctrl_q.en) wr_ok_q <= 1'b1;
      else if (tick)  wr_ok_q <= 1'b0;
      if (fire)                         flag_q <= 1'b1;
      else if (wr_stat && !bus_wdata[1]) flag_q <= 1'b0;
      irq_q <= irq;
    end
  end

  assign irq  = flag_q & ctrl_q.ie;
  assign wake = irq & ~irq_q;

  always_comb begin
    case (rtcw_addr_e'(rd_addr))
      REG_CTRL:   rd_data = CNT_W'(ctrl_q);
      REG_RELOAD: rd_data = reload_q;
      REG_STAT:   rd_data = CNT_W'({flag_q, wr_ok_q});
      default:    rd_data = '0;
    endcase
  end

  // R1: a locked reload write changes nothing
  p_locked_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_RELOAD && !unlocked) |=> $stable(reload_q));
  // R2: sel is frozen while writes are not allowed
  p_sel_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_CTRL && !wr_ok_q) |=> $stable(ctrl_q.sel));
  // R2: disabled timer reports write-allowed next cycle
  p_wrok_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |=> wr_ok_q);
  // R6: every fire leaves the flag set
  p_flag_on_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag_q);
  // R7: clear works regardless of the key state
  p_clear_unprotected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[1] && !fire) |=> !flag_q);
  // R8: wake lasts a single cycle
  p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
endmodule

// File: tb/test_rtc_wkup_timer.sv
module test_rtc_wkup_timer;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, sec_strobe = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0, rd_addr = '0;
  logic [CNT_W-1:0] bus_wdata = '0;
  logic [CNT_W-1:0] rd_data;
  logic irq, wake;

  int cyc = 0, n_chk = 0, n_bad = 0, got_cnt = 0;
  int exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  rtc_wkup_timer #(.CNT_W(CNT_W)) i_rtc_wkup_timer (
    .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .wake(wake)
  );

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: every wake must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && wake) begin
      if (exp_q.size() == 0) chk("R8 unexpected wake", cyc, -1);
      else chk(tag_q.pop_front(), cyc, exp_q.pop_front());
      got_cnt++;
    end
  end

  task automatic wr(input int a, input int d, output int edge_n);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = CNT_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
    edge_n = cyc;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 2'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic unlock();
    int e;
    wr(0, 'hCA, e); wr(0, 'h53, e);
  endtask

  task automatic expect_wake(input string tag, input int at);
    exp_q.push_back(at); tag_q.push_back(tag);
  endtask

  task automatic wait_wakes(input int target, input int limit);
    for (int i = 0; i < limit && got_cnt < target; i++) @(negedge clk);
    chk("wake count", got_cnt, target);
  endtask

  task automatic stop_and_clear();
    int e;
    wr(3, 0, e);
    wr(1, 0, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, e0, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk("R9 irq", int'(irq), 0);
    chk("R9 wake", int'(wake), 0);
    rd(3, v); chk("R9 status", v, 1);
    rd(1, v); chk("R9 ctrl", v, 0);
    rd(2, v); chk("R9 reload", v, 'hFFFF);

    // R1 key protection
    wr(2, 5, e0);   rd(2, v); chk("R1 locked reload", v, 'hFFFF);
    wr(1, 'h18, e0); rd(1, v); chk("R1 locked ctrl", v, 0);
    unlock(); wr(2, 5, e0); rd(2, v); chk("R1 unlocked reload", v, 5);
    wr(0, 'hFF, e0); wr(2, 7, e0); rd(2, v); chk("R1 relock FF", v, 5);
    wr(0, 'hCA, e0); wr(0, 'h11, e0); wr(0, 'h53, e0);
    wr(2, 7, e0); rd(2, v); chk("R1 broken sequence", v, 5);

    // R3 divider modes, reload 2
    for (int m = 0; m < 4; m++) begin
      unlock(); wr(2, 2, e0);
      wr(1, 'h18 | m, e0);
      expect_wake("R3 divider timing", e0 + (16 >> m) * 3);
      wait_wakes(got_cnt + 1, 200);
      stop_and_clear();
      rd(3, v); chk("R7 flag cleared", v, 1);
    end

    // R2 write-allowed handshake
    unlock(); wr(2, 20, e0);
    wr(1, 'h1B, e0);
    expect_wake("R2 reload held", e0 + 2 * 21);
    repeat (3) @(negedge clk);
    rd(3, v); chk("R2 write-allowed low", v, 0);
    wr(2, 3, e0); rd(2, v); chk("R2 reload dropped", v, 20);
    wr(1, 'h18, e0); rd(1, v); chk("R2 sel dropped", v, 'h1B);
    wait_wakes(got_cnt + 1, 200);
    stop_and_clear();
    repeat (2) @(negedge clk);
    rd(3, v); chk("R2 write-allowed back", v, 1);

    // R6 auto-reload
    unlock(); wr(2, 9, e0); wr(1, 'h1B, e0);
    expect_wake("R6 first", e0 + 20);
    expect_wake("R6 second", e0 + 40);
    wait_wakes(got_cnt + 1, 100);
    wr(3, 0, v);
    wait_wakes(got_cnt + 1, 100);
    stop_and_clear();

    // R8 interrupt enable off: flag set, no irq, no wake
    unlock(); wr(2, 1, e0); wr(1, 'h0B, e0);
    repeat (12) @(negedge clk);
    chk("R8 irq masked", int'(irq), 0);
    rd(3, v); chk("R8 flag without irq", v, 2);
    wr(1, 0, e0);
    repeat (2) @(negedge clk);
    // R7 clear while locked; writing 1 does nothing
    wr(0, 'hFF, e0);
    wr(3, 2, e0); rd(3, v); chk("R7 write one ignored", v, 3);
    wr(3, 0, e0); rd(3, v); chk("R7 locked clear", v, 1);

    // R4 strobe mode: clock alone does not count
    unlock(); wr(2, 2, e0); wr(1, 'h1C, e0);
    repeat (100) @(negedge clk);
    rd(3, v); chk("R4 no strobe no count", v, 1);
    @(negedge clk); s = cyc;
    expect_wake("R4 strobe period", s + 3);
    sec_strobe = 1'b1;
    wait_wakes(got_cnt + 1, 50);
    sec_strobe = 1'b0;
    stop_and_clear();

    // R5 extended strobe mode
    unlock(); wr(2, 3, e0); wr(1, 'h1E, e0);
    @(negedge clk); s = cyc;
    expect_wake("R5 extended period", s + 65540);
    sec_strobe = 1'b1;
    wait_wakes(got_cnt + 1, 70000);
    sec_strobe = 1'b0;
    stop_and_clear();

    chk("scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule